// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is the control engine of a single DMA channel. Software programs a source pointer, a destination pointer, a link pointer and a control word through a small register port. It then writes the configuration word with its enable bit set, and the channel starts at once. The channel copies the programmed number of 32-bit words over a single-outstanding memory port. A read from the source address is always followed by a write to the destination address. On a peripheral side, each word waits for that side's request line, and the channel answers with a one-cycle acknowledge.

The engine alone decides the packet length. When a packet finishes, the channel does three things in order. It acknowledges the final request, raises terminal-count status if the control word asks for it, and then either stops or follows the link pointer. To follow the link, it reads a four-word descriptor from memory and runs that packet. A memory error ends the channel at once. A halt bit lets the word in flight finish and holds back every later one until halt is cleared.

Top module: `ll_dma_chan`

## Requirements
- R1: The register offsets are 0 source, 1 destination, 2 link, 3 control and 4 configuration. Offsets 5 and 6 are the clear registers, and offset 7 is status (bit0 terminal count, bit1 error, bit2 active). Configuration bit0 is enable, and writing it as 1 starts the channel. Status bit2 reads 1 while enable is set. After reset all registers read 0 and no memory request or acknowledge is driven.
- R2: Control bits [11:0] hold the word count, [13:12] the width code w, bit14 source increment and bit15 destination increment. Each word is read at the source address and written at the destination address. After each word, an address moves by 1<<w bytes only when its increment bit is set, and the count drops by one. With both sides on memory, words run back to back and a packet of n words clears enable 4n+2 cycles after the enabling write.
- R3: Configuration bit2 marks the source as a peripheral and bit3 marks the destination as a peripheral. A word starts only when the request of every peripheral side is high. The acknowledge of each such side is high for one cycle, three cycles after the request was seen. No word moves without a request.
- R4: When a packet finishes with a link pointer of 0, the channel clears its enable bit and status bit2 reads 0.
- R5: When a packet finishes with a nonzero link pointer, the channel reads the source, destination, link and control words at link+0, +4, +8 and +12. It loads them into the registers and runs that packet.
- R6: Each finished packet sets terminal-count status if control bit16 is set. irq_tc_o is this status ANDed with configuration bit4.
- R7: Configuration bit1 is halt. A word already in flight completes. While halt is 1, no new word starts regardless of requests, and clearing halt resumes the transfer.
- R8: A memory error response sets error status, clears enable and fetches no descriptor. irq_err_o is error status ANDed with configuration bit5.
- R9: Writing bit0 = 1 to offset 5 clears terminal-count status, and writing bit0 = 1 to offset 6 clears error status. A write of 0, or a write to the other clear register, leaves the status unchanged.
- R10: A memory request keeps its address, direction and data until mem_rvalid_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rvalid_i | input | 1 | Memory response, ends the request |
| mem_err_i | input | 1 | Error flag qualifying the response |
| mem_rdata_i | input | 32 | Memory read data |
| src_req_i | input | 1 | Source peripheral request |
| src_ack_o | output | 1 | Source peripheral acknowledge |
| dst_req_i | input | 1 | Destination peripheral request |
| dst_ack_o | output | 1 | Destination peripheral acknowledge |
| irq_tc_o | output | 1 | Masked terminal-count interrupt |
| irq_err_o | output | 1 | Masked error interrupt |

## Verification
With a zero-wait memory, a peripheral acknowledge is due exactly three cycles after its request is raised. The bench raises requests on a falling edge and counts falling edges until the acknowledge appears. A memory-only packet must drop the active bit after exactly 4n+2 rising edges counted from the enabling write, and the bench polls status once per cycle to compare against that figure. Status, pointer and memory contents are read only once the active bit has fallen, so each result is final when sampled. Halt and missing-request windows are checked by watching several whole cycles for any acknowledge or write.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
  localparam int unsigned AW    = 32;
  localparam int unsigned DW    = 32;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned RA_W  = 3;
  localparam int unsigned NPTR  = 3;

  typedef enum logic [RA_W-1:0] {
    RA_SRC = 3'd0, RA_DST = 3'd1, RA_NXT = 3'd2, RA_CTRL = 3'd3,
    RA_CFG = 3'd4, RA_TCCLR = 3'd5, RA_ERRCLR = 3'd6, RA_STAT = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic             tc_ie;
    logic             dst_inc;
    logic             src_inc;
    logic [1:0]       width;
    logic [CNT_W-1:0] count;
  } ctrl_t;
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    logic err_mask;
    logic tc_mask;
    logic dst_per;
    logic src_per;
    logic halt;
    logic en;
  } cfg_t;
  localparam int unsigned CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_ACK, ST_DONE, ST_FETCH
  } state_e;
endpackage

// File: rtl/ll_dma_regs.sv
module ll_dma_regs
  import ll_dma_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sw_we_i,
  input  logic [RA_W-1:0]          sw_addr_i,
  input  logic [DW-1:0]            sw_wdata_i,
  output logic [DW-1:0]            sw_rdata_o,
  input  logic [NPTR-1:0]          ptr_we_i,
  input  logic [NPTR-1:0][AW-1:0]  ptr_d_i,
  input  logic                     ctrl_we_i,
  input  ctrl_t                    ctrl_d_i,
  input  logic                     clr_en_i,
  input  logic                     set_tc_i,
  input  logic                     set_err_i,
  output logic [NPTR-1:0][AW-1:0]  ptr_o,
  output ctrl_t                    ctrl_o,
  output cfg_t                     cfg_o,
  output logic                     tc_stat_o,
  output logic                     err_stat_o
);
  logic wr_ctrl, wr_cfg, wr_tcclr, wr_errclr;
  assign wr_ctrl   = sw_we_i && (sw_addr_i == RA_CTRL);
  assign wr_cfg    = sw_we_i && (sw_addr_i == RA_CFG);
  assign wr_tcclr  = sw_we_i && (sw_addr_i == RA_TCCLR) && sw_wdata_i[0];
  assign wr_errclr = sw_we_i && (sw_addr_i == RA_ERRCLR) && sw_wdata_i[0];

  // source, destination, link: engine update wins over software write
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [AW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (ptr_we_i[g])                         q <= ptr_d_i[g];
      else if (sw_we_i && sw_addr_i == RA_W'(g))    q <= sw_wdata_i;
    end
    assign ptr_o[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= '0;
    else if (ctrl_we_i) ctrl_o <= ctrl_d_i;
    else if (wr_ctrl)   ctrl_o <= ctrl_t'(sw_wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_o <= '0;
    else begin
      if (wr_cfg)   cfg_o    <= cfg_t'(sw_wdata_i[CFG_W-1:0]);
      if (clr_en_i) cfg_o.en <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tc_stat_o <= 1'b0;
    else if (set_tc_i) tc_stat_o <= 1'b1;
    else if (wr_tcclr) tc_stat_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_stat_o <= 1'b0;
    else if (set_err_i) err_stat_o <= 1'b1;
    else if (wr_errclr) err_stat_o <= 1'b0;
  end

  always_comb begin
    case (reg_addr_e'(sw_addr_i))
      RA_SRC:  sw_rdata_o = ptr_o[0];
      RA_DST:  sw_rdata_o = ptr_o[1];
      RA_NXT:  sw_rdata_o = ptr_o[2];
      RA_CTRL: sw_rdata_o = DW'(ctrl_o);
      RA_CFG:  sw_rdata_o = DW'(cfg_o);
      RA_STAT: sw_rdata_o = DW'({cfg_o.en, err_stat_o, tc_stat_o});
      default: sw_rdata_o = '0;
    endcase
  end

  assert_w1c_tc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tcclr && !set_tc_i) |=> !tc_stat_o);
  assert_w1c_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_errclr && !set_err_i) |=> !err_stat_o);
endmodule

// File: rtl/ll_dma_seq.sv
module ll_dma_seq
  import ll_dma_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     halt_i,
  input  logic                     src_per_i,
  input  logic                     dst_per_i,
  input  ctrl_t                    ctrl_i,
  input  logic [NPTR-1:0][AW-1:0]  ptr_i,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [AW-1:0]            mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  input  logic                     mem_rvalid_i,
  input  logic                     mem_err_i,
  input  logic [DW-1:0]            mem_rdata_i,
  input  logic                     src_req_i,
  input  logic                     dst_req_i,
  output logic                     src_ack_o,
  output logic                     dst_ack_o,
  output logic [NPTR-1:0]          ptr_we_o,
  output logic [NPTR-1:0][AW-1:0]  ptr_d_o,
  output logic                     ctrl_we_o,
  output ctrl_t                    ctrl_d_o,
  output logic                     clr_en_o,
  output logic                     set_tc_o,
  output logic                     set_err_o
);
  state_e        state_q, state_d;
  logic [DW-1:0] data_q;
  logic [1:0]    fidx_q;
  logic [AW-1:0] fbase_q;
  logic [AW-1:0] step;
  logic          go;

  assign step = {{(AW-1){1'b0}}, 1'b1} << ctrl_i.width;
  assign go   = !halt_i && (!src_per_i || src_req_i) && (!dst_per_i || dst_req_i);

  always_comb begin
    state_d     = state_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_i[0];
    mem_wdata_o = data_q;
    src_ack_o   = 1'b0;
    dst_ack_o   = 1'b0;
    ptr_we_o    = '0;
    ptr_d_o[0]  = ptr_i[0] + step;
    ptr_d_o[1]  = ptr_i[1] + step;
    ptr_d_o[2]  = mem_rdata_i;
    ctrl_we_o   = 1'b0;
    ctrl_d_o    = ctrl_i;
    ctrl_d_o.count = ctrl_i.count - 1'b1;
    clr_en_o    = 1'b0;
    set_tc_o    = 1'b0;
    set_err_o   = 1'b0;
    case (state_q)
      ST_IDLE: if (en_i) state_d = (ctrl_i.count != '0) ? ST_WAIT : ST_DONE;
      ST_WAIT: begin
        if (!en_i)   state_d = ST_IDLE;
        else if (go) state_d = ST_RD;
      end
      ST_RD: begin
        mem_req_o = 1'b1;
        if (mem_rvalid_i) begin
          if (mem_err_i) begin
            set_err_o = 1'b1; clr_en_o = 1'b1; state_d = ST_IDLE;
          end else state_d = ST_WR;
        end
      end
      ST_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = ptr_i[1];
        if (mem_rvalid_i) begin
          if (mem_err_i) begin
            set_err_o = 1'b1; clr_en_o = 1'b1; state_d = ST_IDLE;
          end else begin
            ptr_we_o[0] = ctrl_i.src_inc;
            ptr_we_o[1] = ctrl_i.dst_inc;
            ctrl_we_o   = 1'b1;
            state_d     = ST_ACK;
          end
        end
      end
      ST_ACK: begin
        src_ack_o = src_per_i;
        dst_ack_o = dst_per_i;
        state_d   = (ctrl_i.count == '0) ? ST_DONE : ST_WAIT;
      end
      ST_DONE: begin
        set_tc_o = ctrl_i.tc_ie;
        if (ptr_i[2] == '0) begin
          clr_en_o = 1'b1; state_d = ST_IDLE;
        end else state_d = ST_FETCH;
      end
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = fbase_q + AW'({fidx_q, 2'b00});
        if (mem_rvalid_i) begin
          if (mem_err_i) begin
            set_err_o = 1'b1; clr_en_o = 1'b1; state_d = ST_IDLE;
          end else if (fidx_q == 2'd3) begin
            ctrl_we_o = 1'b1;
            ctrl_d_o  = ctrl_t'(mem_rdata_i[CTRL_W-1:0]);
            state_d   = ST_IDLE;
          end else begin
            ptr_we_o[fidx_q] = 1'b1;
            ptr_d_o[0] = mem_rdata_i;
            ptr_d_o[1] = mem_rdata_i;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      fidx_q  <= '0;
      fbase_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD && mem_rvalid_i) data_q <= mem_rdata_i;
      if (state_q == ST_DONE) begin
        fidx_q  <= '0;
        fbase_q <= ptr_i[2];
      end else if (state_q == ST_FETCH && mem_rvalid_i && !mem_err_i) begin
        fidx_q <= fidx_q + 2'd1;
      end
    end
  end

  assert_halt_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && halt_i) |=> (state_q != ST_RD));
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR && mem_rvalid_i && !mem_err_i) |-> (ctrl_i.count != '0));
endmodule

// File: rtl/ll_dma_chan.sv
module ll_dma_chan
  import ll_dma_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RA_W-1:0] reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_rvalid_i,
  input  logic            mem_err_i,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            src_req_i,
  output logic            src_ack_o,
  input  logic            dst_req_i,
  output logic            dst_ack_o,
  output logic            irq_tc_o,
  output logic            irq_err_o
);
  logic [NPTR-1:0]         ptr_we;
  logic [NPTR-1:0][AW-1:0] ptr_d, ptr_q;
  logic                    ctrl_we, clr_en, set_tc, set_err, tc_stat, err_stat;
  ctrl_t                   ctrl_d, ctrl_q;
  cfg_t                    cfg_q;

  ll_dma_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (reg_we_i),
    .sw_addr_i  (reg_addr_i),
    .sw_wdata_i (reg_wdata_i),
    .sw_rdata_o (reg_rdata_o),
    .ptr_we_i   (ptr_we),
    .ptr_d_i    (ptr_d),
    .ctrl_we_i  (ctrl_we),
    .ctrl_d_i   (ctrl_d),
    .clr_en_i   (clr_en),
    .set_tc_i   (set_tc),
    .set_err_i  (set_err),
    .ptr_o      (ptr_q),
    .ctrl_o     (ctrl_q),
    .cfg_o      (cfg_q),
    .tc_stat_o  (tc_stat),
    .err_stat_o (err_stat)
  );

  ll_dma_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (cfg_q.en),
    .halt_i       (cfg_q.halt),
    .src_per_i    (cfg_q.src_per),
    .dst_per_i    (cfg_q.dst_per),
    .ctrl_i       (ctrl_q),
    .ptr_i        (ptr_q),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_err_i    (mem_err_i),
    .mem_rdata_i  (mem_rdata_i),
    .src_req_i    (src_req_i),
    .dst_req_i    (dst_req_i),
    .src_ack_o    (src_ack_o),
    .dst_ack_o    (dst_ack_o),
    .ptr_we_o     (ptr_we),
    .ptr_d_o      (ptr_d),
    .ctrl_we_o    (ctrl_we),
    .ctrl_d_o     (ctrl_d),
    .clr_en_o     (clr_en),
    .set_tc_o     (set_tc),
    .set_err_o    (set_err)
  );

  assign irq_tc_o  = tc_stat  & cfg_q.tc_mask;
  assign irq_err_o = err_stat & cfg_q.err_mask;

  assert_err_stops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i && mem_err_i) |=> (!cfg_q.en && err_stat));
  assert_tc_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_stat) |-> $past(ctrl_q.tc_ie));
  assert_ack_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ack_o || dst_ack_o) |=> !(src_ack_o || dst_ack_o));
endmodule

// File: tb/ll_dma_chan_test.sv
`timescale 1ns/1ps
module ll_dma_chan_test;
  localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_NXT = 3'd2, A_CTRL = 3'd3,
                         A_CFG = 3'd4, A_TCC = 3'd5, A_ERC = 3'd6, A_STAT = 3'd7;
  localparam logic [31:0] C_EN = 32'd1, C_HALT = 32'd2, C_SP = 32'd4, C_DP = 32'd8,
                          C_TCM = 32'd16, C_ERM = 32'd32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        src_req = 1'b0, dst_req = 1'b0, src_ack, dst_ack, irq_tc, irq_err;

  logic [31:0] mem [64];
  logic [31:0] expm [64];
  logic        slow = 1'b0, err_on = 1'b0;
  logic [5:0]  err_idx = '0;
  int          wcnt = 0, nwr = 0, r10_bad = 0;
  logic        pend = 1'b0;
  logic [31:0] paddr = '0;
  int          total = 0, fails = 0;

  ll_dma_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .src_req_i(src_req), .src_ack_o(src_ack), .dst_req_i(dst_req), .dst_ack_o(dst_ack),
    .irq_tc_o(irq_tc), .irq_err_o(irq_err));

  assign mem_rvalid = mem_req && (!slow || wcnt != 0);
  assign mem_rdata  = mem[mem_addr[7:2]];
  assign mem_err    = mem_req && err_on && (mem_addr[7:2] == err_idx);

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_rvalid && !mem_err) begin
      mem[mem_addr[7:2]] <= mem_wdata;
      nwr++;
    end
    wcnt <= (mem_req && !mem_rvalid) ? wcnt + 1 : 0;
    if (pend && (!mem_req || mem_addr != paddr)) r10_bad++;
    pend  <= mem_req && !mem_rvalid;
    paddr <= mem_addr;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wait_idle(input int maxc, output int cyc);
    logic [31:0] s;
    cyc = 0; rd(A_STAT, s);
    while (s[2] && cyc < maxc) begin
      @(posedge clk); cyc++; @(negedge clk); rd(A_STAT, s);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) mem[i] = (i < 16 || i >= 32) ? 32'hC0DE_0000 + 32'(i * 7) : 32'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int cyc, c;
    bit seen;
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_STAT, s);
    chk(s == 0 && !mem_req && !src_ack && !dst_ack && !irq_tc && !irq_err, "R1 reset state", s, 0);
    rd(A_CFG, s);
    chk(s == 0, "R1 cfg after reset", s, 0);

    // memory-to-memory sweep: widths x increment flags
    for (int w = 0; w < 3; w++) begin
      for (int inc = 0; inc < 4; inc++) begin
        int n;
        logic [31:0] sa, da, ctl, exp_src;
        n = 2 + inc;
        slow = (w == 2);
        fill();
        for (int i = 0; i < 64; i++) expm[i] = mem[i];
        for (int k = 0; k < n; k++) begin
          sa = 32'h4  + (inc[0] ? 32'(k) << w : 32'h0);
          da = 32'h44 + (inc[1] ? 32'(k) << w : 32'h0);
          expm[da[7:2]] = expm[sa[7:2]];
        end
        exp_src = inc[0] ? 32'h4 + (32'(n) << w) : 32'h4;
        wr(A_TCC, 1); wr(A_ERC, 1);
        ctl = 32'(n) | (32'(w) << 12) | (32'(inc[0]) << 14) | (32'(inc[1]) << 15) | (32'(inc[0]) << 16);
        wr(A_SRC, 32'h4); wr(A_DST, 32'h44); wr(A_NXT, 0); wr(A_CTRL, ctl);
        wr(A_CFG, C_EN | C_TCM);
        wait_idle(400, cyc);
        if (!slow) chk(cyc == 4 * n + 2, "R2 back-to-back cycle count", 32'(cyc), 32'(4 * n + 2));
        rd(A_STAT, s);
        chk(s[2] == 1'b0, "R4 enable cleared after single packet", s, 0);
        chk(s[0] == inc[0] && irq_tc == inc[0], "R6 tc per tc_ie", {s[0], irq_tc}, {inc[0], inc[0]});
        rd(A_SRC, s);
        chk(s == exp_src, "R2 source pointer advance", s, exp_src);
        c = 0;
        for (int i = 16; i < 32; i++) if (mem[i] !== expm[i]) c++;
        chk(c == 0, "R2 copied data", 32'(c), 0);
      end
    end
    slow = 1'b0;
    chk(r10_bad == 0, "R10 request held until response", 32'(r10_bad), 0);

    // peripheral pacing: t0 p2m, t1 m2p, t2 p2p
    for (int t = 0; t < 3; t++) begin
      logic sp, dp;
      int w0;
      sp = (t != 1); dp = (t != 0);
      fill();
      wr(A_SRC, 32'h4); wr(A_DST, 32'h44); wr(A_NXT, 0);
      wr(A_CTRL, 32'd3 | (32'd2 << 12) | (32'd1 << 14));
      wr(A_CFG, C_EN | (sp ? C_SP : 0) | (dp ? C_DP : 0));
      for (int k = 0; k < 3; k++) begin
        w0 = nwr; seen = 1'b0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); if (src_ack || dst_ack) seen = 1'b1; end
        chk(nwr == w0 && !seen, "R3 no word without request", 32'(nwr - w0), 0);
        src_req = sp; dst_req = dp;
        c = 0;
        do begin @(negedge clk); c++; end while (!(src_ack || dst_ack) && c < 10);
        chk(c == 3, "R3 ack latency", 32'(c), 3);
        chk({dst_ack, src_ack} == {dp, sp}, "R3 ack on peripheral sides", {dst_ack, src_ack}, {dp, sp});
        src_req = 1'b0; dst_req = 1'b0;
      end
      wait_idle(50, cyc);
      chk(mem[17] == mem[3], "R3 last word delivered", mem[17], mem[3]);
    end

    // halt: word in flight completes, later requests held off
    fill();
    wr(A_SRC, 32'h4); wr(A_DST, 32'h44); wr(A_NXT, 0);
    wr(A_CTRL, 32'd2 | (32'd2 << 12) | (32'd3 << 14));
    wr(A_CFG, C_EN | C_DP);
    repeat (2) @(negedge clk);
    dst_req = 1'b1;
    wr(A_CFG, C_EN | C_DP | C_HALT);
    c = 0;
    while (!dst_ack && c < 6) begin @(negedge clk); c++; end
    chk(dst_ack == 1'b1, "R7 in-flight word completes", dst_ack, 1);
    dst_req = 1'b0;
    @(negedge clk);
    dst_req = 1'b1;
    c = nwr; seen = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (dst_ack) seen = 1'b1; end
    chk(!seen && nwr == c, "R7 halted channel ignores request", 32'(nwr - c), 0);
    wr(A_CFG, C_EN | C_DP);
    c = 0;
    while (!dst_ack && c < 8) begin @(negedge clk); c++; end
    chk(dst_ack == 1'b1, "R7 resume after halt cleared", dst_ack, 1);
    dst_req = 1'b0;
    wait_idle(50, cyc);
    chk(mem[18] == mem[2], "R7 second word moved", mem[18], mem[2]);

    // linked descriptor
    fill();
    mem[32] = 32'h20; mem[33] = 32'h60; mem[34] = 32'h0;
    mem[35] = 32'd3 | (32'd2 << 12) | (32'd1 << 14) | (32'd1 << 15) | (32'd1 << 16);
    wr(A_TCC, 1); wr(A_ERC, 1);
    wr(A_SRC, 32'h4); wr(A_DST, 32'h44); wr(A_NXT, 32'h80);
    wr(A_CTRL, 32'd2 | (32'd2 << 12) | (32'd3 << 14));
    wr(A_CFG, C_EN);
    wait_idle(200, cyc);
    c = 0;
    for (int i = 0; i < 2; i++) if (mem[17 + i] != mem[1 + i]) c++;
    for (int i = 0; i < 3; i++) if (mem[24 + i] != mem[8 + i]) c++;
    chk(c == 0, "R5 both packets copied", 32'(c), 0);
    rd(A_SRC, s);  chk(s == 32'h2C, "R5 source from descriptor", s, 32'h2C);
    rd(A_NXT, s);  chk(s == 0, "R5 link loaded", s, 0);
    rd(A_CTRL, s); chk(s == (mem[35] & ~32'hFFF), "R5 control loaded", s, mem[35] & ~32'hFFF);
    rd(A_STAT, s);
    chk(s[0] == 1'b1 && irq_tc == 1'b0, "R6 tc set but masked", {s[0], irq_tc}, 2'b10);
    wr(A_ERC, 1);
    rd(A_STAT, s); chk(s[0] == 1'b1, "R9 other clear leaves tc", s, 1);
    wr(A_TCC, 0);
    rd(A_STAT, s); chk(s[0] == 1'b1, "R9 zero write leaves tc", s, 1);
    wr(A_TCC, 1);
    rd(A_STAT, s); chk(s[0] == 1'b0, "R9 tc cleared", s, 0);

    // memory error
    fill();
    mem[32] = 32'h20; mem[33] = 32'h60; mem[34] = 32'h0; mem[35] = 32'd1;
    err_on = 1'b1; err_idx = 6'd2;
    wr(A_SRC, 32'h4); wr(A_DST, 32'h44); wr(A_NXT, 32'h80);
    wr(A_CTRL, 32'd3 | (32'd2 << 12) | (32'd3 << 14) | (32'd1 << 16));
    wr(A_CFG, C_EN | C_ERM | C_TCM);
    wait_idle(100, cyc);
    err_on = 1'b0;
    rd(A_STAT, s);
    chk(s[2:0] == 3'b010 && irq_err, "R8 error status, enable off, no tc", {s[2:0], irq_err}, 4'b0101);
    rd(A_NXT, s);  chk(s == 32'h80, "R8 no descriptor fetched", s, 32'h80);
    rd(A_CTRL, s); chk(s[11:0] == 12'd2, "R8 aborted after one word", s[11:0], 2);
    chk(mem[17] == mem[1] && mem[18] == 0, "R8 only first word written", mem[18], 0);
    wr(A_TCC, 1);
    rd(A_STAT, s); chk(s[1] == 1'b1, "R9 other clear leaves error", s, 2);
    wr(A_ERC, 1);
    rd(A_STAT, s); chk(s[1] == 1'b0 && !irq_err, "R9 error cleared", s, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule